// File: doc/BRIEF.md
# Key-Gated Scan Path Switch

This block is a one-bit test data register that works as a switch in a reconfigurable scan network. A shift stage sits in the scan path. Behind it, a held stage decides whether a downstream scan segment is spliced into the active path (open) or bypassed (closed). The TAP controller drives all sequencing. It supplies capture, shift and update strobes, a select line and an active-low test reset, all timed to the test clock.

The switch is guarded by a key. An update that asks for "open" is accepted only when a key vector, taken from cells elsewhere in the same scan chain, equals a constant set when the block is built. A request to close is accepted under any key. Loading a 1 into the shift stage and then updating therefore cannot open the segment unless the key is right. The held stage is a two-state machine with states SEG_CLOSED and SEG_OPEN. It has these transitions:
- CLOSE_REQ: any state to SEG_CLOSED, when the shift bit is 0.
- OPEN_GRANT: to SEG_OPEN, when the shift bit is 1 and the key matches.
- OPEN_DENY: no change, when the shift bit is 1 and the key is wrong.
- TEST_RESET: to SEG_CLOSED, asynchronously.

Top module: `key_gated_sib`

## Requirements
- R1: While test reset is low, the held stage is closed, the shift stage is 0, `scan_out` is 0 and `seg_sel` is 0.
- R2: On a clock edge with `sel` and `capture_en` high, the shift stage loads 1 if the held stage is open and 0 if it is closed. Capture takes priority over a shift in the same cycle.
- R3: On a clock edge with `sel` and `shift_en` high and no capture, the shift stage loads `scan_in`. While the held stage is closed, `scan_out` equals the shift stage.
- R4: While `sel` is low, capture, shift and update strobes change neither the shift stage nor the held stage.
- R5: An update with `sel` high, shift stage 1 and `key_vec` equal to `KEY_VALUE` (default 8'hA5) opens the held stage.
- R6: An update with shift stage 1 and `key_vec` not equal to `KEY_VALUE` leaves the held stage unchanged. In particular, a closed stage stays closed.
- R7: An update with `sel` high and shift stage 0 closes the held stage, whatever the value of `key_vec`.
- R8: While the held stage is open, `scan_out` equals `seg_return`.
- R9: `seg_sel` is high exactly when `sel` is high and the held stage is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| sel | input | 1 | This register is selected by the TAP |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| scan_in | input | 1 | Serial scan data in |
| seg_return | input | 1 | Scan output of the downstream segment |
| key_vec | input | KEY_W | Key bits from elsewhere in the chain |
| scan_out | output | 1 | Serial scan data out |
| seg_sel | output | 1 | Select toward the downstream segment |

## Verification
The hardest case to reach is an update that asks to open while the key differs from the constant in only one bit. It must be seen from both states: when closed, the segment must stay bypassed, and when already open, the segment must stay inserted. The stimulus table drives this directly. It shifts a 1 into the stage, then updates with key 8'hA4 while closed and with a wrong key while open. After each update it reads `scan_out` against `seg_return` and checks `seg_sel`, which shows which state the held stage is in.

// File: rtl/key_gated_sib_pkg.sv
package key_gated_sib_pkg;
    typedef enum logic {
        SEG_CLOSED = 1'b0,
        SEG_OPEN   = 1'b1
    } seg_state_e;
endpackage

// File: rtl/ksib_shift_cell.sv
module ksib_shift_cell (
    input  logic tck,
    input  logic trst_n,
    input  logic sel,
    input  logic capture_en,
    input  logic shift_en,
    input  logic scan_in,
    input  logic held_open,
    output logic shift_bit
);
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            shift_bit <= 1'b0;
        end else if (sel && capture_en) begin
            shift_bit <= held_open;
        end else if (sel && shift_en) begin
            shift_bit <= scan_in;
        end
    end
endmodule

// File: rtl/ksib_update_fsm.sv
module ksib_update_fsm
    import key_gated_sib_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter logic [KEY_W-1:0] KEY_VALUE = 8'hA5
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             sel,
    input  logic             update_en,
    input  logic             shift_bit,
    input  logic [KEY_W-1:0] key_vec,
    output logic             held_open
);
    seg_state_e state_q, state_d;
    logic       key_ok;
    logic       upd_go;

    assign key_ok = (key_vec == KEY_VALUE);
    assign upd_go = sel && update_en;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= SEG_CLOSED;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEG_CLOSED: begin
                if (upd_go && shift_bit && key_ok) state_d = SEG_OPEN;
            end
            SEG_OPEN: begin
                if (upd_go && !shift_bit) state_d = SEG_CLOSED;
            end
            default: state_d = SEG_CLOSED;
        endcase
    end

    always_comb begin
        held_open = (state_q == SEG_OPEN);
    end
endmodule

// File: rtl/ksib_out_mux.sv
module ksib_out_mux (
    input  logic held_open,
    input  logic sel,
    input  logic shift_bit,
    input  logic seg_return,
    output logic scan_out,
    output logic seg_sel
);
    always_comb begin
        scan_out = held_open ? seg_return : shift_bit;
        seg_sel  = sel && held_open;
    end
endmodule

// File: rtl/key_gated_sib.sv
module key_gated_sib #(
    parameter int KEY_W = 8,
    parameter logic [KEY_W-1:0] KEY_VALUE = 8'hA5
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             sel,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic             scan_in,
    input  logic             seg_return,
    input  logic [KEY_W-1:0] key_vec,
    output logic             scan_out,
    output logic             seg_sel
);
    logic shift_bit;
    logic held_open;

    ksib_shift_cell u_shift (
        .tck(tck), .trst_n(trst_n), .sel(sel), .capture_en(capture_en),
        .shift_en(shift_en), .scan_in(scan_in), .held_open(held_open),
        .shift_bit(shift_bit)
    );

    ksib_update_fsm #(.KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE)) u_upd (
        .tck(tck), .trst_n(trst_n), .sel(sel), .update_en(update_en),
        .shift_bit(shift_bit), .key_vec(key_vec), .held_open(held_open)
    );

    ksib_out_mux u_mux (
        .held_open(held_open), .sel(sel), .shift_bit(shift_bit),
        .seg_return(seg_return), .scan_out(scan_out), .seg_sel(seg_sel)
    );
endmodule

// File: rtl/key_gated_sib_chk.sv
module key_gated_sib_chk #(
    parameter int KEY_W = 8,
    parameter logic [KEY_W-1:0] KEY_VALUE = 8'hA5
) (
    input logic             tck,
    input logic             trst_n,
    input logic             sel,
    input logic             update_en,
    input logic             seg_return,
    input logic [KEY_W-1:0] key_vec,
    input logic             scan_out,
    input logic             shift_q,
    input logic             open_q
);
    // R5
    a_r5_open_with_key: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && update_en && shift_q && key_vec == KEY_VALUE) |=> open_q);
    // R6
    a_r6_wrong_key_stays_closed: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && update_en && shift_q && key_vec != KEY_VALUE && !open_q) |=> !open_q);
    // R7
    a_r7_close_any_key: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && update_en && !shift_q) |=> !open_q);
    // R4
    a_r4_unselected_stable: assert property (@(posedge tck) disable iff (!trst_n)
        !sel |=> ($stable(open_q) && $stable(shift_q)));
    // R8
    a_r8_return_when_open: assert property (@(posedge tck) disable iff (!trst_n)
        open_q |-> (scan_out == seg_return));
endmodule

bind key_gated_sib key_gated_sib_chk #(.KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE)) u_chk (
    .tck(tck), .trst_n(trst_n), .sel(sel), .update_en(update_en),
    .seg_return(seg_return), .key_vec(key_vec), .scan_out(scan_out),
    .shift_q(shift_bit), .open_q(held_open)
);

// File: tb/key_gated_sib_tb_top.sv
`timescale 1ns/1ps
module key_gated_sib_tb_top;
    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       sel = 1'b0, capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
    logic       scan_in = 1'b0, seg_return = 1'b0;
    logic [7:0] key_vec = 8'h00;
    logic       scan_out, seg_sel;
    int         n_chk = 0, n_fail = 0;

    always #2.5 tck = ~tck;

    key_gated_sib #(.KEY_W(8), .KEY_VALUE(8'hA5)) dut_i (
        .tck(tck), .trst_n(trst_n), .sel(sel), .capture_en(capture_en),
        .shift_en(shift_en), .update_en(update_en), .scan_in(scan_in),
        .seg_return(seg_return), .key_vec(key_vec), .scan_out(scan_out),
        .seg_sel(seg_sel)
    );

    typedef struct packed {
        logic       s, c, sh, u, si, ret;
        logic [7:0] key;
        logic       e_out, e_sel;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VT [NV] = '{
        '{1,0,1,0,1,0,8'h00,1,0,4'd3},  // R3 shift 1 in
        '{1,0,0,1,0,0,8'h00,1,0,4'd6},  // R6 wrong key, stays closed
        '{1,1,0,0,0,0,8'h00,0,0,4'd2},  // R2 capture closed -> 0
        '{1,0,1,0,1,0,8'h00,1,0,4'd3},  // R3
        '{1,0,0,1,0,0,8'hA5,0,1,4'd5},  // R5 right key opens
        '{1,0,0,0,0,1,8'h00,1,1,4'd8},  // R8 return routed
        '{1,1,0,0,0,0,8'h00,0,1,4'd2},  // R2 capture open -> 1
        '{1,0,1,0,0,1,8'h00,1,1,4'd8},  // R8 shift 0 while open
        '{1,0,0,1,0,1,8'h00,0,0,4'd7},  // R7 close with wrong key
        '{0,0,1,0,1,0,8'h00,0,0,4'd4},  // R4 no shift unselected
        '{1,0,1,0,1,0,8'h00,1,0,4'd3},  // R3
        '{0,0,0,1,0,0,8'hA5,1,0,4'd4},  // R4 no update unselected
        '{1,0,0,1,0,0,8'hA4,1,0,4'd6},  // R6 one bit off
        '{1,0,0,1,0,0,8'hA5,0,1,4'd5},  // R5
        '{1,0,0,1,0,1,8'h00,1,1,4'd6},  // R6 open stays open
        '{0,0,0,0,0,1,8'h00,1,0,4'd9},  // R9 sel low hides select
        '{0,0,0,0,0,0,8'h00,0,0,4'd9}   // R9
    };

    task automatic check(input logic a, input logic e, input string what);
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", what, a, e);
        end
    endtask

    task automatic step(input logic s, c, sh, u, si, ret, input logic [7:0] k);
        @(negedge tck);
        sel = s; capture_en = c; shift_en = sh; update_en = u;
        scan_in = si; seg_return = ret; key_vec = k;
        @(posedge tck);
        #1;
    endtask

    initial begin
        #1000000;
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        sel = 1'b1;
        repeat (3) @(posedge tck);
        #1;
        check(scan_out, 1'b0, "R1 scan_out in reset");
        check(seg_sel, 1'b0, "R1 seg_sel in reset");
        @(negedge tck); trst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VT[i].s, VT[i].c, VT[i].sh, VT[i].u, VT[i].si, VT[i].ret, VT[i].key);
            check(scan_out, VT[i].e_out, $sformatf("R%0d row %0d scan_out", VT[i].req, i));
            check(seg_sel, VT[i].e_sel, $sformatf("R%0d row %0d seg_sel", VT[i].req, i));
        end

        // R2: close, then capture and shift together -> capture wins
        step(1,0,1,0,0,0,8'h00);
        step(1,0,0,1,0,0,8'h00);
        check(scan_out, 1'b0, "R7 closed before priority test");
        step(1,1,1,0,1,0,8'h00);
        check(scan_out, 1'b0, "R2 capture beats shift");

        // R1: reset while open
        step(1,0,1,0,1,0,8'h00);
        step(1,0,0,1,0,1,8'hA5);
        check(seg_sel, 1'b1, "R5 open before reset");
        @(negedge tck); update_en = 1'b0; trst_n = 1'b0;
        #1;
        check(seg_sel, 1'b0, "R1 reset closes seg_sel");
        check(scan_out, 1'b0, "R1 reset clears scan_out");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule